// File: doc/BRIEF.md
# Dual-Group Parallel Port Controller

This block provides 48 general-purpose digital lines for a host that reaches it through a small byte-wide register bus. The lines come in two identical groups. Each group has three 8-bit ports (A, B and C) and one control register. Port C is split into a low nibble and a high nibble, and each nibble has its own direction. The pad drivers are represented as a 48-bit output value plus a 48-bit output enable. Input pins pass through a synchronizer before the host can read them.

A control write with the top bit set is a configuration word. It loads the directions and the mode fields of its group, and it also forces every driver of that group into tristate. Drive comes back only when the host writes the exact value 0x00 to the same control register. Mode fields for the strobed and bidirectional modes are stored and read back, but the ports always behave as simple latched outputs and sampled inputs.

Top module: `dual_pio`

## Requirements
- R1: After reset, every output enable is 0, every output latch is 0, and each control register reads 0x1B (all ports input, modes 0, drivers not forced off).
- R2: Offsets 0, 1 and 2 are ports A, B and C of group 0, and offset 3 is its control register. Offsets 4 to 7 are the same layout for group 1. Pin bit index = (group*3 + port)*8 + bit, with port A=0, B=1, C=2.
- R3: A control write with bit 7 = 1 stores bits 6:0 and drives every output enable of that group to 0 from the next cycle. The control register then reads back with bit 7 = 1.
- R4: A control write of exactly 0x00 clears the forced tristate of its group and leaves its stored configuration unchanged. Any other write with bit 7 = 0 has no effect.
- R5: Control bit 0 sets the direction of C0-C3, bit 1 sets port B, bit 3 sets C4-C7 and bit 4 sets port A, with 1 = input. An output enable is 1 exactly when its line is an output and its group is not forced to tristate.
- R6: A write to a port offset stores the byte in that port's output latch, whatever the direction. pinOut always shows the latches. The two nibbles of port C drive independently, so 0x0F written to C drives only C0-C3 high when they are outputs.
- R7: A port read returns, bit by bit, the output latch for output lines and the synchronized pin for input lines. A pin change is visible after SYNC_STAGES clock edges.
- R8: Mode fields (bit 2, and bits 6:5 where 00, 01 and 1X are all accepted) are stored and read back, and they have no effect on drive or read behaviour.
- R9: Offsets 8 to 15 read as 0x00, and writes to them change no state.
- R10: The two groups are independent. A write to one group never changes the other group's latches, configuration or enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Register offset |
| wrEn | input | 1 | Write strobe, one cycle per write |
| wrData | input | 8 | Write data |
| rdEn | input | 1 | Read strobe (enables the read mux) |
| rdData | output | 8 | Read data, combinational from addr |
| pinIn | input | 48 | Pad input values |
| pinOut | output | 48 | Pad output values |
| pinOe | output | 48 | Pad output enables, 1 = drive |

## Verification
The bench interleaves random writes to all sixteen offsets with random pin values, and it biases control writes toward configuration words, the exact 0x00 drive-restore code and other values with bit 7 clear. These patterns separate a design that restores drive on any write with bit 7 clear from one that waits for the exact 0x00 code. Random direction words with every pin pattern show whether a read mixes latch and pin correctly, bit by bit and nibble by nibble. Directed cases cover the port C nibble example, the three mode encodings, writes to the unused offsets and the isolation between the groups.

// File: rtl/dual_pio_pkg.sv
package dual_pio_pkg;
  localparam int GROUPS = 2;
  localparam int PORTS = 3;
  localparam int REGS_PER_GROUP = 4;
  localparam int PORT_W = 8;
  localparam int LINES = GROUPS * PORTS * PORT_W;
  localparam logic [6:0] CFG_RESET = 7'h1B;

  typedef struct packed {
    logic [GROUPS-1:0][PORTS-1:0] portWr;
    logic [GROUPS-1:0] cfgLoad;
    logic [GROUPS-1:0] drvOn;
    logic [GROUPS-1:0][REGS_PER_GROUP-1:0] rdSel;
    logic [PORT_W-1:0] data;
  } pioStrobe_t;
endpackage

// File: rtl/dual_pio_ctrl.sv
module dual_pio_ctrl
  import dual_pio_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic wrEn,
  input  logic rdEn,
  input  logic [PORT_W-1:0] wrData,
  output pioStrobe_t strobe
);
  always_comb begin
    strobe = '0;
    strobe.data = wrData;
    for (int g = 0; g < GROUPS; g++) begin
      for (int r = 0; r < REGS_PER_GROUP; r++) begin
        if (addr == ADDR_W'(g * REGS_PER_GROUP + r)) begin
          strobe.rdSel[g][r] = rdEn;
          if (r < PORTS) begin
            strobe.portWr[g][r] = wrEn;
          end else begin
            strobe.cfgLoad[g] = wrEn && wrData[PORT_W-1];
            strobe.drvOn[g] = wrEn && (wrData == '0);
          end
        end
      end
    end
  end
endmodule

// File: rtl/dual_pio_data.sv
module dual_pio_data
  import dual_pio_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  pioStrobe_t strobe,
  input  logic [LINES-1:0] pinIn,
  output logic [LINES-1:0] pinOut,
  output logic [LINES-1:0] pinOe,
  output logic [PORT_W-1:0] rdData
);
  localparam int HALF = PORT_W / 2;

  logic [LINES-1:0] syncPipe [SYNC_STAGES];
  logic [LINES-1:0] pinSync;
  logic [LINES-1:0] inMask;
  logic [6:0] cfgWord [GROUPS];
  logic [GROUPS-1:0] triState;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncPipe[s] <= '0;
    end else begin
      syncPipe[0] <= pinIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncPipe[s] <= syncPipe[s-1];
    end
  end
  assign pinSync = syncPipe[SYNC_STAGES-1];

  for (genvar g = 0; g < GROUPS; g++) begin : gGroup
    localparam int BASE = g * PORTS * PORT_W;

    always_ff @(posedge clk) begin
      if (rst) begin
        cfgWord[g] <= CFG_RESET;
        triState[g] <= 1'b0;
      end else if (strobe.cfgLoad[g]) begin
        cfgWord[g] <= strobe.data[6:0];
        triState[g] <= 1'b1;
      end else if (strobe.drvOn[g]) begin
        triState[g] <= 1'b0;
      end
    end

    for (genvar p = 0; p < PORTS; p++) begin : gPort
      always_ff @(posedge clk) begin
        if (rst) pinOut[BASE + p*PORT_W +: PORT_W] <= '0;
        else if (strobe.portWr[g][p]) pinOut[BASE + p*PORT_W +: PORT_W] <= strobe.data;
      end
    end

    assign inMask[BASE +: PORT_W] = {PORT_W{cfgWord[g][4]}};
    assign inMask[BASE + PORT_W +: PORT_W] = {PORT_W{cfgWord[g][1]}};
    assign inMask[BASE + 2*PORT_W +: HALF] = {HALF{cfgWord[g][0]}};
    assign inMask[BASE + 2*PORT_W + HALF +: HALF] = {HALF{cfgWord[g][3]}};
    assign pinOe[BASE +: PORTS*PORT_W] =
      ~inMask[BASE +: PORTS*PORT_W] & {PORTS*PORT_W{~triState[g]}};
  end

  always_comb begin
    rdData = '0;
    for (int g = 0; g < GROUPS; g++) begin
      for (int r = 0; r < REGS_PER_GROUP; r++) begin
        if (strobe.rdSel[g][r]) begin
          if (r < PORTS) begin
            for (int b = 0; b < PORT_W; b++) begin
              rdData[b] |= inMask[(g*PORTS + r)*PORT_W + b]
                         ? pinSync[(g*PORTS + r)*PORT_W + b]
                         : pinOut[(g*PORTS + r)*PORT_W + b];
            end
          end else begin
            rdData |= {triState[g], cfgWord[g]};
          end
        end
      end
    end
  end
endmodule

// File: rtl/dual_pio.sv
module dual_pio
  import dual_pio_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic wrEn,
  input  logic [7:0] wrData,
  input  logic rdEn,
  output logic [7:0] rdData,
  input  logic [47:0] pinIn,
  output logic [47:0] pinOut,
  output logic [47:0] pinOe
);
  pioStrobe_t strobe;

  dual_pio_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .addr(addr), .wrEn(wrEn), .rdEn(rdEn), .wrData(wrData), .strobe(strobe)
  );

  dual_pio_data #(.SYNC_STAGES(SYNC_STAGES)) uData (
    .clk(clk), .rst(rst), .strobe(strobe), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe), .rdData(rdData)
  );
endmodule

// File: rtl/dual_pio_chk.sv
module dual_pio_chk #(
  parameter int ADDR_W = 4
) (
  input logic clk,
  input logic rst,
  input logic [ADDR_W-1:0] addr,
  input logic wrEn,
  input logic [7:0] wrData,
  input logic rdEn,
  input logic [7:0] rdData,
  input logic [47:0] pinOut,
  input logic [47:0] pinOe
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    $fell(rst) |-> (pinOe == '0 && pinOut == '0));

  a_r3_cfg_tristates_g0: assert property (@(posedge clk) disable iff (rst)
    (wrEn && addr == ADDR_W'(3) && wrData[7]) |=> (pinOe[23:0] == '0));

  a_r3_cfg_tristates_g1: assert property (@(posedge clk) disable iff (rst)
    (wrEn && addr == ADDR_W'(7) && wrData[7]) |=> (pinOe[47:24] == '0));

  a_r4_oe_moves_on_ctrl_only: assert property (@(posedge clk) disable iff (rst)
    (!$stable(pinOe) && !$past(rst)) |->
      $past(wrEn && (addr == ADDR_W'(3) || addr == ADDR_W'(7))));

  a_r5_portb_uniform_g0: assert property (@(posedge clk) disable iff (rst)
    ($countones(pinOe[15:8]) == 0 || $countones(pinOe[15:8]) == 8));

  a_r6_out_moves_on_port_write: assert property (@(posedge clk) disable iff (rst)
    (!$stable(pinOut) && !$past(rst)) |->
      $past(wrEn && addr < ADDR_W'(8) && addr != ADDR_W'(3) && addr != ADDR_W'(7)));

  a_r9_high_offsets_zero: assert property (@(posedge clk) disable iff (rst)
    (rdEn && addr >= ADDR_W'(8)) |-> (rdData == 8'h00));
endmodule

bind dual_pio dual_pio_chk #(.ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rst(rst), .addr(addr), .wrEn(wrEn), .wrData(wrData),
  .rdEn(rdEn), .rdData(rdData), .pinOut(pinOut), .pinOe(pinOe)
);

// File: tb/dual_pio_test.sv
module dual_pio_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] addr = '0;
  logic wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic rdEn = 1'b0;
  logic [7:0] rdData;
  logic [47:0] pinIn = '0;
  logic [47:0] pinOut;
  logic [47:0] pinOe;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  logic [6:0] mCfg [2];
  logic mTri [2];
  logic [7:0] mLatch [2][3];

  dual_pio uut (
    .clk(clk), .rst(rst), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdData), .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<=150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic logic [7:0] inMaskOf(int g, int p);
    case (p)
      0: return {8{mCfg[g][4]}};
      1: return {8{mCfg[g][1]}};
      default: return {{4{mCfg[g][3]}}, {4{mCfg[g][0]}}};
    endcase
  endfunction

  function automatic logic [47:0] expOe();
    logic [47:0] v;
    for (int g = 0; g < 2; g++)
      for (int p = 0; p < 3; p++)
        v[(g*3+p)*8 +: 8] = ~inMaskOf(g, p) & {8{~mTri[g]}};
    return v;
  endfunction

  function automatic logic [47:0] expOut();
    logic [47:0] v;
    for (int g = 0; g < 2; g++)
      for (int p = 0; p < 3; p++)
        v[(g*3+p)*8 +: 8] = mLatch[g][p];
    return v;
  endfunction

  function automatic logic [7:0] expRead(int a);
    int g, r;
    if (a >= 8) return 8'h00;
    g = a / 4;
    r = a % 4;
    if (r == 3) return {mTri[g], mCfg[g]};
    return (mLatch[g][r] & ~inMaskOf(g, r)) | (pinIn[(g*3+r)*8 +: 8] & inMaskOf(g, r));
  endfunction

  task automatic check(string req, logic [47:0] act, logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int g = 0; g < 2; g++) begin
      mCfg[g] = 7'h1B;
      mTri[g] = 1'b0;
      for (int p = 0; p < 3; p++) mLatch[g][p] = '0;
    end
  endtask

  task automatic wr(int a, logic [7:0] d);
    @(negedge clk);
    addr = 4'(a);
    wrData = d;
    wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    if (a < 8) begin
      if (a % 4 < 3) mLatch[a/4][a%4] = d;
      else if (d[7]) begin
        mCfg[a/4] = d[6:0];
        mTri[a/4] = 1'b1;
      end else if (d == 8'h00) mTri[a/4] = 1'b0;
    end
  endtask

  task automatic rdCheck(int a, string req);
    @(negedge clk);
    addr = 4'(a);
    rdEn = 1'b1;
    #1;
    check(req, {40'h0, rdData}, {40'h0, expRead(a)});
    rdEn = 1'b0;
  endtask

  task automatic setPins(logic [47:0] v);
    @(negedge clk);
    pinIn = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic checkPads(string req);
    check(req, pinOe, expOe());
    check(req, pinOut, expOut());
  endtask

  initial begin
    int seed;
    seed = 32'h5eed_0123;
    void'($urandom(seed));
    modelReset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checkPads("R1 reset pads");
    rdCheck(3, "R1 reset ctrl g0");
    rdCheck(7, "R1 reset ctrl g1");

    // R6: port C nibble example, C low output, C high input
    wr(3, 8'h9A);
    wr(2, 8'h0F);
    checkPads("R3 cfg forces tristate");
    wr(3, 8'h00);
    checkPads("R4 0x00 restores drive, R6 nibble drive");
    setPins(48'h0000_00A0_0000);
    rdCheck(2, "R7 port C mixed read");

    // R4: nonzero write with bit 7 clear ignored
    wr(3, 8'h80);
    wr(3, 8'h05);
    checkPads("R4 ignored control write");
    rdCheck(3, "R4 ctrl unchanged");

    // R8: mode encodings stored, behaviour unchanged
    wr(7, 8'hE4);
    wr(7, 8'h00);
    rdCheck(7, "R8 mode 2 readback");
    checkPads("R8 mode 2 drive");
    wr(7, 8'hA0);
    wr(7, 8'h00);
    wr(4, 8'h3C);
    checkPads("R8 mode 1 drive, R10 isolation");
    rdCheck(4, "R8 mode 1 port A read");
    rdCheck(3, "R10 other group untouched");

    // R9: high offsets
    wr(12, 8'hFF);
    wr(11, 8'h80);
    checkPads("R9 high offset write ignored");
    for (int a = 8; a < 16; a++) rdCheck(a, "R9 high offset read");

    // Random phase
    for (int i = 0; i < 600; i++) begin
      int sel;
      int a;
      logic [7:0] d;
      sel = $urandom_range(0, 9);
      a = $urandom_range(0, 15);
      d = 8'($urandom);
      if (sel < 3) begin
        a = ($urandom_range(0, 1) != 0) ? 7 : 3;
        d[7] = 1'b1;
      end else if (sel == 3) begin
        a = ($urandom_range(0, 1) != 0) ? 7 : 3;
        d = 8'h00;
      end else if (sel == 4) begin
        a = ($urandom_range(0, 1) != 0) ? 7 : 3;
        d[7] = 1'b0;
        if (d == 8'h00) d = 8'h11;
      end
      if (sel == 9) setPins({16'($urandom), 32'($urandom)});
      else wr(a, d);
      checkPads("R5 R6 R10 random pads");
      rdCheck($urandom_range(0, 15), "R2 R7 random read");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule